// File: doc/BRIEF.md
# Indexed CPU Configuration Register File

This block is a bank of processor configuration bytes reached through two ports: an index port and a data port. A write on the index port picks a register number. After that the data port reads or writes the picked register. The bank holds eight control bytes, a 24-byte address-range array and an 8-byte region-control array. It also derives the system-management memory window from three of the range bytes: a base address and a byte size.

Each group of register numbers has its own access rule. The rules are built from four things: a mapping-enable nibble in control byte 3, a range-access enable bit in control byte 5, a lock bit in control byte 3, and the `in_smm` input. Writes that fail the rule are dropped. Reads that fail the rule return 0xFF. Some bits are protected once the lock is set. The block also raises one-cycle pulses: one when the window header must be invalidated, and one when the management-access bit changes.

Top module: `cfgrf_top`

## Requirements
- R1: A write on the index port stores `wdata` as the current index, and later data writes go to that index. `rdata` shows the byte at the current index at all times. Control bytes 0–3 sit at 0xC0–0xC3, bytes 4–6 at 0xE8–0xEA and byte 7 at 0xEB. The range array starts at 0xC4 and the region-control array at 0xDC.
- R2: After reset every control byte is 0 except byte 4, which is 0x80. Both arrays are 0, the index is 0, and the window is disabled (`smm_en`=0, `smm_size`=0, `smm_base`=0).
- R3: A data write to an index whose access rule is false leaves all state unchanged. A read of such an index returns 0xFF, and so does a read of any index outside the groups listed in R1.
- R4: Byte 1 bit 1 enables SMI use, bit 2 grants management access and bit 7 selects management mode 3. While byte 3 bit 0 (the lock) is 1 and `in_smm` is 0, a write to byte 1 keeps these three bits and updates the others.
- R5: While locked and `in_smm`=0, a write to byte 3 keeps bit 1, forces bit 0 to 1 and takes the other bits from `wdata`.
- R6: Indices 0xC4–0xCC need byte 5 bit 5. Indices 0xCD–0xCF are open when byte 5 bit 5 is 1, or the lock is 0, or `in_smm` is 1.
- R7: Indices 0xD0–0xDB need byte 3 bits [7:4] equal to 1 and also byte 5 bit 5. Indices 0xDC–0xE3 and 0xE8–0xEA need only byte 3 bits [7:4] equal to 1. Bytes 0–3 and byte 7 are always open.
- R8: `smm_base` bits [31:24] come from 0xCD, bits [23:16] from 0xCE and bits [15:12] from the upper nibble of 0xCF. Its low 12 bits are 0.
- R9: The low nibble n of 0xCF sets `smm_size`: 0 gives size 0 and `smm_en`=0, 0xF gives 2^32, and any other n gives 2048 << n.
- R10: Every accepted write to 0xCD–0xCF raises `hdr_inval` for exactly the next cycle.
- R11: Byte 7 keeps only bits 0 and 2 of the written value. All its other bits read 0.
- R12: When a write changes byte 1 bit 2, `smac_evt` is 1 for the next cycle. `smac_on` always shows the present value of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Index-port write strobe |
| dat_wr | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write data for either port |
| in_smm | input | 1 | Processor is in management mode |
| rdata | output | 8 | Data-port read value for the current index |
| smm_base | output | 32 | Management window base address |
| smm_size | output | 33 | Management window size in bytes |
| smm_en | output | 1 | Management window enabled |
| hdr_inval | output | 1 | One-cycle header-invalidate pulse |
| smac_evt | output | 1 | One-cycle pulse on a change of the access bit |
| smac_on | output | 1 | Present value of the access bit |

## Verification
The assertions assume that `idx_wr` and `dat_wr` are never high in the same cycle. They also assume that `in_smm` does not change during the cycle of a data write, so the lock checks compare against the same mode the write saw. The stimulus follows both rules. Each access is a separate index cycle followed by a data cycle, and `in_smm` is changed only between accesses. Writes to byte 3 are often given an upper nibble of 1, so the mapped groups are reached often. The lock is set and cleared many times through management-mode writes.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;
    localparam int BYTE_W    = 8;
    localparam int ARR_BYTES = 24;
    localparam int RCR_BYTES = 8;
    localparam int CCR_NUM   = 8;
    localparam int ARR_AW    = $clog2(ARR_BYTES);
    localparam int RCR_AW    = $clog2(RCR_BYTES);
    localparam int SIZE_W    = 33;

    localparam logic [7:0] IX_C0     = 8'hC0;
    localparam logic [7:0] IX_C1     = 8'hC1;
    localparam logic [7:0] IX_C3     = 8'hC3;
    localparam logic [7:0] IX_ARR0   = 8'hC4;
    localparam logic [7:0] IX_ARRG   = 8'hCC;
    localparam logic [7:0] IX_WIN0   = 8'hCD;
    localparam logic [7:0] IX_WIN1   = 8'hCE;
    localparam logic [7:0] IX_WIN2   = 8'hCF;
    localparam logic [7:0] IX_ARRM0  = 8'hD0;
    localparam logic [7:0] IX_ARRM1  = 8'hDB;
    localparam logic [7:0] IX_RGN0   = 8'hDC;
    localparam logic [7:0] IX_RGN1   = 8'hE3;
    localparam logic [7:0] IX_C4     = 8'hE8;
    localparam logic [7:0] IX_C6     = 8'hEA;
    localparam logic [7:0] IX_C7     = 8'hEB;

    localparam logic [7:0] PROT1_MASK = 8'h86;  // use-SMI, access, mode-3
    localparam logic [7:0] NMI_MASK   = 8'h02;
    localparam logic [7:0] LOCK_MASK  = 8'h01;
    localparam logic [7:0] C7_MASK    = 8'h05;
    localparam logic [7:0] C4_RESET   = 8'h80;
    localparam int         SMAC_BIT   = 2;
    localparam int         ARR_EN_BIT = 5;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_OPEN,
        GRP_ARR_LOW,
        GRP_WIN,
        GRP_ARR_MAP,
        GRP_MAPPED
    } grp_e;

    typedef struct packed {
        logic map_en;
        logic arr_en;
        logic lock;
        logic smm;
    } gate_t;

    function automatic grp_e classify(input logic [7:0] ix);
        if ((ix >= IX_C0 && ix <= IX_C3) || ix == IX_C7) return GRP_OPEN;
        if (ix >= IX_ARR0 && ix <= IX_ARRG)              return GRP_ARR_LOW;
        if (ix >= IX_WIN0 && ix <= IX_WIN2)              return GRP_WIN;
        if (ix >= IX_ARRM0 && ix <= IX_ARRM1)            return GRP_ARR_MAP;
        if ((ix >= IX_RGN0 && ix <= IX_RGN1) || (ix >= IX_C4 && ix <= IX_C6))
            return GRP_MAPPED;
        return GRP_NONE;
    endfunction

    function automatic logic grp_open(input grp_e g, input gate_t s);
        case (g)
            GRP_OPEN:    return 1'b1;
            GRP_ARR_LOW: return s.arr_en;
            GRP_WIN:     return s.arr_en | ~s.lock | s.smm;
            GRP_ARR_MAP: return s.map_en & s.arr_en;
            GRP_MAPPED:  return s.map_en;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic [SIZE_W-1:0] win_size(input logic [3:0] code);
        if (code == 4'h0) return '0;
        if (code == 4'hF) return SIZE_W'(1) << 32;
        return SIZE_W'(2048) << code;
    endfunction
endpackage

// File: rtl/cfgrf_gate.sv
module cfgrf_gate
    import cfgrf_pkg::*;
(
    input  logic [7:0] ix,
    input  logic [3:0] map_nib,
    input  logic       arr_en,
    input  logic       lock,
    input  logic       in_smm,
    output grp_e       grp,
    output logic       allow
);
    gate_t st;

    always_comb begin
        st.map_en = (map_nib == 4'h1);
        st.arr_en = arr_en;
        st.lock   = lock;
        st.smm    = in_smm;
        grp       = classify(ix);
        allow     = grp_open(grp, st);
    end
endmodule

// File: rtl/cfgrf_win_decode.sv
module cfgrf_win_decode
    import cfgrf_pkg::*;
(
    input  logic [7:0]        hi_byte,
    input  logic [7:0]        mid_byte,
    input  logic [7:0]        lo_byte,
    output logic [31:0]       base,
    output logic [SIZE_W-1:0] size,
    output logic              en
);
    always_comb begin
        base = {hi_byte, mid_byte, lo_byte[7:4], 12'h000};
        size = win_size(lo_byte[3:0]);
        en   = (lo_byte[3:0] != 4'h0);
    end
endmodule

// File: rtl/cfgrf_top.sv
module cfgrf_top
    import cfgrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [7:0]        wdata,
    input  logic              in_smm,
    output logic [7:0]        rdata,
    output logic [31:0]       smm_base,
    output logic [SIZE_W-1:0] smm_size,
    output logic              smm_en,
    output logic              hdr_inval,
    output logic              smac_evt,
    output logic              smac_on
);
    logic [7:0] index_q;
    logic [7:0] ccr   [CCR_NUM];
    logic [7:0] arr_q [ARR_BYTES];
    logic [7:0] rgn_q [RCR_BYTES];

    grp_e        grp;
    logic        allow;
    logic        prot;
    logic [7:0]  ccr1_nx, ccr3_nx;
    logic [ARR_AW-1:0] arr_off;
    logic [RCR_AW-1:0] rgn_off;
    logic [2:0]  slot;

    cfgrf_gate u_gate (
        .ix      (index_q),
        .map_nib (ccr[3][7:4]),
        .arr_en  (ccr[5][ARR_EN_BIT]),
        .lock    (ccr[3][0]),
        .in_smm  (in_smm),
        .grp     (grp),
        .allow   (allow)
    );

    cfgrf_win_decode u_win (
        .hi_byte  (arr_q[int'(IX_WIN0 - IX_ARR0)]),
        .mid_byte (arr_q[int'(IX_WIN1 - IX_ARR0)]),
        .lo_byte  (arr_q[int'(IX_WIN2 - IX_ARR0)]),
        .base     (smm_base),
        .size     (smm_size),
        .en       (smm_en)
    );

    always_comb begin
        prot    = ccr[3][0] & ~in_smm;
        ccr1_nx = prot ? ((wdata & ~PROT1_MASK) | (ccr[1] & PROT1_MASK)) : wdata;
        ccr3_nx = prot ? ((wdata & ~NMI_MASK) | (ccr[3] & NMI_MASK) | LOCK_MASK) : wdata;
        arr_off = ARR_AW'(index_q - IX_ARR0);
        rgn_off = RCR_AW'(index_q - IX_RGN0);
        slot    = (index_q >= IX_C4) ? {1'b1, index_q[1:0]} : {1'b0, index_q[1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q   <= '0;
            hdr_inval <= 1'b0;
            smac_evt  <= 1'b0;
            for (int i = 0; i < CCR_NUM; i++)   ccr[i]   <= (i == 4) ? C4_RESET : 8'h00;
            for (int i = 0; i < ARR_BYTES; i++) arr_q[i] <= '0;
            for (int i = 0; i < RCR_BYTES; i++) rgn_q[i] <= '0;
        end else begin
            hdr_inval <= 1'b0;
            smac_evt  <= 1'b0;
            if (idx_wr) index_q <= wdata;
            if (dat_wr && allow) begin
                case (grp)
                    GRP_OPEN: begin
                        if (index_q == IX_C1) begin
                            ccr[1]   <= ccr1_nx;
                            smac_evt <= ccr1_nx[SMAC_BIT] ^ ccr[1][SMAC_BIT];
                        end else if (index_q == IX_C3) begin
                            ccr[3] <= ccr3_nx;
                        end else if (index_q == IX_C7) begin
                            ccr[7] <= wdata & C7_MASK;
                        end else begin
                            ccr[slot] <= wdata;
                        end
                    end
                    GRP_ARR_LOW, GRP_ARR_MAP: arr_q[arr_off] <= wdata;
                    GRP_WIN: begin
                        arr_q[arr_off] <= wdata;
                        hdr_inval      <= 1'b1;
                    end
                    GRP_MAPPED: begin
                        if (index_q <= IX_RGN1) rgn_q[rgn_off] <= wdata;
                        else                    ccr[slot]      <= wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = 8'hFF;
        if (allow) begin
            case (grp)
                GRP_OPEN:                          rdata = ccr[slot];
                GRP_ARR_LOW, GRP_WIN, GRP_ARR_MAP: rdata = arr_q[arr_off];
                GRP_MAPPED: rdata = (index_q <= IX_RGN1) ? rgn_q[rgn_off] : ccr[slot];
                default:                           rdata = 8'hFF;
            endcase
        end
    end

    assign smac_on = ccr[1][SMAC_BIT];

    // R4: protected bits of byte 1 survive a locked write outside management mode
    assert_lock_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && index_q == IX_C1 && ccr[3][0] && !in_smm)
        |=> ((ccr[1] & PROT1_MASK) == $past(ccr[1] & PROT1_MASK)));

    // R5: the lock cannot be cleared outside management mode
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ccr[3][0] && !in_smm && !(dat_wr && index_q == IX_C3 && in_smm)) |=> ccr[3][0]);

    // R3: a refused write leaves the window untouched
    assert_refused_write_R3: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !idx_wr && !allow) |=> ($stable(smm_base) && $stable(smm_size)));

    // R10: header invalidate only follows a data write
    assert_inval_cause_R10: assert property (@(posedge clk) disable iff (rst)
        hdr_inval |-> $past(dat_wr));

    // R11: byte 7 never holds bits outside its mask
    assert_c7_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && index_q == IX_C7) |=> ((ccr[7] & ~C7_MASK) == 8'h00));

    // R12: the access-bit event goes with a real change of the bit
    assert_smac_change_R12: assert property (@(posedge clk) disable iff (rst)
        smac_evt |-> (smac_on != $past(smac_on)));
endmodule

// File: tb/cfgrf_top_test.sv
`timescale 1ns/100ps
module cfgrf_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_wr = 1'b0, dat_wr = 1'b0, in_smm = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [31:0] smm_base;
    logic [32:0] smm_size;
    logic        smm_en, hdr_inval, smac_evt, smac_on;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [7:0] m_ccr [8];
    logic [7:0] m_arr [24];
    logic [7:0] m_rgn [8];

    always #2.5 clk = ~clk;

    cfgrf_top uut (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .dat_wr(dat_wr), .wdata(wdata),
        .in_smm(in_smm), .rdata(rdata), .smm_base(smm_base), .smm_size(smm_size),
        .smm_en(smm_en), .hdr_inval(hdr_inval), .smac_evt(smac_evt), .smac_on(smac_on)
    );

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_allow(input logic [7:0] ix, input bit smm);
        bit mp = (m_ccr[3][7:4] == 4'h1);
        bit ae = m_ccr[5][5];
        bit lk = m_ccr[3][0];
        if ((ix >= 8'hC0 && ix <= 8'hC3) || ix == 8'hEB) return 1;
        if (ix >= 8'hC4 && ix <= 8'hCC) return ae;
        if (ix >= 8'hCD && ix <= 8'hCF) return ae || !lk || smm;
        if (ix >= 8'hD0 && ix <= 8'hDB) return mp && ae;
        if ((ix >= 8'hDC && ix <= 8'hE3) || (ix >= 8'hE8 && ix <= 8'hEA)) return mp;
        return 0;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] ix, input bit smm);
        if (!m_allow(ix, smm)) return 8'hFF;
        if (ix <= 8'hC3) return m_ccr[ix - 8'hC0];
        if (ix <= 8'hDB) return m_arr[ix - 8'hC4];
        if (ix <= 8'hE3) return m_rgn[ix - 8'hDC];
        return m_ccr[4 + ix - 8'hE8];
    endfunction

    function automatic logic [32:0] m_size();
        logic [3:0] c = m_arr[11][3:0];
        if (c == 0) return 0;
        if (c == 4'hF) return 33'h1_0000_0000;
        return 33'd2048 << c;
    endfunction

    function automatic string tag_of(input logic [7:0] ix);
        if (ix == 8'hC1) return "R4";
        if (ix == 8'hC3) return "R5";
        if (ix == 8'hEB) return "R11";
        if (ix == 8'hC0 || ix == 8'hC2) return "R1";
        if (ix >= 8'hC4 && ix <= 8'hCF) return "R6";
        if (ix >= 8'hD0 && ix <= 8'hEA && !(ix > 8'hE3 && ix < 8'hE8)) return "R7";
        return "R3";
    endfunction

    task automatic m_write(input logic [7:0] ix, input logic [7:0] v, input bit smm,
                           output bit e_inv, output bit e_evt);
        bit pr = m_ccr[3][0] && !smm;
        e_inv = 0; e_evt = 0;
        if (!m_allow(ix, smm)) return;
        if (ix == 8'hC1) begin
            logic [7:0] nv = pr ? ((v & 8'h79) | (m_ccr[1] & 8'h86)) : v;
            e_evt = nv[2] ^ m_ccr[1][2];
            m_ccr[1] = nv;
        end else if (ix == 8'hC3) begin
            m_ccr[3] = pr ? ((v & 8'hFD) | (m_ccr[3] & 8'h02) | 8'h01) : v;
        end else if (ix == 8'hEB) m_ccr[7] = v & 8'h05;
        else if (ix <= 8'hC3) m_ccr[ix - 8'hC0] = v;
        else if (ix <= 8'hDB) begin
            m_arr[ix - 8'hC4] = v;
            e_inv = (ix >= 8'hCD && ix <= 8'hCF);
        end else if (ix <= 8'hE3) m_rgn[ix - 8'hDC] = v;
        else m_ccr[4 + ix - 8'hE8] = v;
    endtask

    task automatic sel(input logic [7:0] ix);
        @(negedge clk); idx_wr = 1; wdata = ix;
        @(negedge clk); idx_wr = 0;
    endtask

    task automatic access(input logic [7:0] ix, input logic [7:0] v, input bit smm);
        bit ei, ee;
        in_smm = smm;
        sel(ix);
        dat_wr = 1; wdata = v;
        m_write(ix, v, smm, ei, ee);
        @(negedge clk); dat_wr = 0;
        chk("R10", hdr_inval, ei);
        chk("R12", smac_evt, ee);
        chk("R12", smac_on, m_ccr[1][2]);
        chk(tag_of(ix), rdata, m_read(ix, smm));
        chk("R8", smm_base, {m_arr[9], m_arr[10], m_arr[11][7:4], 12'h0});
        chk("R9", smm_size, m_size());
        chk("R9", smm_en, m_arr[11][3:0] != 0);
    endtask

    task automatic peek(input logic [7:0] ix, input string tag);
        sel(ix);
        chk(tag, rdata, m_read(ix, in_smm));
    endtask

    function automatic logic [7:0] pick(input int n);
        case (n % 20)
            0: return 8'hC0;  1: return 8'hC1;  2: return 8'hC2;  3: return 8'hC3;
            4: return 8'hC4;  5: return 8'hC8;  6: return 8'hCC;  7: return 8'hCD;
            8: return 8'hCE;  9: return 8'hCF; 10: return 8'hD0; 11: return 8'hDB;
            12: return 8'hDC; 13: return 8'hE3; 14: return 8'hE8; 15: return 8'hE9;
            16: return 8'hEA; 17: return 8'hEB; 18: return 8'h30; default: return 8'hF0;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++)  m_ccr[i] = (i == 4) ? 8'h80 : 8'h00;
        for (int i = 0; i < 24; i++) m_arr[i] = 8'h00;
        for (int i = 0; i < 8; i++)  m_rgn[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        // R2: reset state
        chk("R2", smm_en, 0); chk("R2", smm_size, 0); chk("R2", smm_base, 0);
        chk("R2", rdata, 8'hFF);                    // index 0 is unimplemented
        peek(8'hC1, "R2");
        peek(8'hE8, "R2");                          // gated: 0xFF
        access(8'hC3, 8'h10, 0);                    // enable mapping
        peek(8'hE8, "R2");                          // now 0x80
        peek(8'hDC, "R2");
        // R8 / R9 directed window decode, lock clear
        access(8'hCD, 8'h12, 0);
        access(8'hCE, 8'h34, 0);
        access(8'hCF, 8'h51, 0);
        chk("R9", smm_size, 33'd4096);
        chk("R8", smm_base, 32'h1234_5000);
        access(8'hCF, 8'hAF, 0);
        chk("R9", smm_size, 33'h1_0000_0000);
        access(8'hCF, 8'h00, 0);
        chk("R9", smm_en, 0);
        // R4 / R5 / R12 lock behaviour
        access(8'hC1, 8'h86, 0);
        access(8'hC3, 8'h13, 0);                    // lock with NMI bit set
        access(8'hC1, 8'h00, 0);                    // protected bits kept
        access(8'hC3, 8'h10, 0);                    // bit0 forced, bit1 kept
        access(8'hCD, 8'hAA, 0);                    // refused: locked, arr off
        chk("R3", smm_base[31:24], 8'h12);
        access(8'hCD, 8'hBB, 1);                    // allowed inside SMM
        access(8'hC1, 8'h00, 1);                    // clears access bit
        access(8'hC3, 8'h10, 1);                    // unlock inside SMM
        access(8'hEB, 8'hFF, 0);                    // R11
        access(8'h30, 8'h55, 0);                    // R3 unimplemented
        // random mix
        for (int k = 0; k < 1500; k++) begin
            logic [7:0] ix = pick(int'($urandom_range(0, 19)));
            logic [7:0] v  = 8'($urandom);
            bit smm = ($urandom_range(0, 3) == 0);
            if (ix == 8'hC3 && $urandom_range(0, 1)) v[7:4] = 4'h1;
            access(ix, v, smm);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule